// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver

This block joins two 18-bit buses, side A and side B. Each direction has its own path and its own storage element. A path can pass data straight through, hold a stored word, or capture a new word on a falling clock edge. Each path also has its own drive enable. The enable for the A-to-B path is active high, and the enable for the B-to-A path is active low. Pad tri-stating is left to the pad ring: each side gets a data output plus a separate drive-enable output.

The latch and the clock-edge behaviour are rebuilt in synchronous logic. A fast system clock samples each path's latch-enable and capture clock. A capture-clock falling edge is a sample taken low right after a sample taken high. While a path's latch enable is high, its output is taken combinationally from its input, and the storage element follows the input at every system clock edge. When both paths drive at the same time, a status output flags bus contention.

Top module: `ubt_xcvr`

## Requirements
- R1: While `le_ab` is 1, `b_out` equals `a_in` in the same cycle. While `le_ba` is 1, `a_out` equals `b_in` in the same cycle.
- R2: While `le_ab` is 0 and no falling edge of `ck_ab` is seen, `b_out` keeps its stored word whatever `a_in` does. A rising `ck_ab` edge does not capture.
- R3: While `le_ab` is 0, a system clock edge that samples `ck_ab` low, after the previous edge sampled it high, stores `a_in`. After that edge, `b_out` shows the stored word.
- R4: When `le_ab` falls, the stored word is the `a_in` value sampled at the last system clock edge where `le_ab` was 1. This holds whether `ck_ab` is low or high at that moment.
- R5: `b_drive` is 1 exactly when `en_ab` is 1 (active high).
- R6: `a_drive` is 1 exactly when `en_ba_n` is 0 (active low).
- R7: The B-to-A path follows R2 to R4 using `le_ba`, `ck_ba` and `b_in` in place of `le_ab`, `ck_ab` and `a_in`, and presents its word on `a_out`.
- R8: A path keeps capturing and tracking while its drive is off. Once the drive is turned on, it presents the word it stored while disabled.
- R9: A synchronous, active-high `rst` clears both stored words to zero. With the latch enables at 0, both outputs then read zero.
- R10: `contention` is 1 exactly when `a_drive` and `b_drive` are both 1.
- R11: Activity on one path does not change the stored word or the output of the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data received from side A |
| a_out | output | 18 | Data for side A (from the B-to-A path) |
| a_drive | output | 1 | Drive enable for the side A pads |
| b_in | input | 18 | Data received from side B |
| b_out | output | 18 | Data for side B (from the A-to-B path) |
| b_drive | output | 1 | Drive enable for the side B pads |
| en_ab | input | 1 | A-to-B drive enable, active high |
| en_ba_n | input | 1 | B-to-A drive enable, active low |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| ck_ab | input | 1 | A-to-B capture clock, falling edge active |
| ck_ba | input | 1 | B-to-A capture clock, falling edge active |
| contention | output | 1 | Both sides driven at once |

## Verification
The hold and capture properties assume that a latch enable, a capture clock and the matching data input are each steady over a whole system clock period. They also assume that each capture-clock level lasts at least one period, so that every falling edge is sampled as a high-then-low pair. The stimulus keeps within these assumptions: it changes every control and data input only at the falling system clock edge, and it holds each capture-clock level for at least one full period. It also keeps `rst` high from time zero until the first sampled edge, so the sampled-clock register starts from a defined value.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  parameter int unsigned UBT_W = 18;

  typedef enum logic {
    OE_ACT_LOW  = 1'b0,
    OE_ACT_HIGH = 1'b1
  } oe_pol_e;
endpackage

// File: rtl/ubt_fall_det.sv
module ubt_fall_det (
  input  logic clk,
  input  logic sig,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    sig_q <= sig;
  end

  assign fall = sig_q & ~sig;
endmodule

// File: rtl/ubt_path.sv
module ubt_path #(
  parameter int unsigned     W   = ubt_pkg::UBT_W,
  parameter ubt_pkg::oe_pol_e POL = ubt_pkg::OE_ACT_HIGH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         ck,
  input  logic         oe,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic         fall;
  logic [W-1:0] held_q;

  ubt_fall_det u_fall (
    .clk  (clk),
    .sig  (ck),
    .fall (fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (le || fall) begin
      held_q <= din;
    end
  end

  assign dout = le ? din : held_q;

  generate
    if (POL == ubt_pkg::OE_ACT_HIGH) begin : g_oe_hi
      assign drive = oe;
    end else begin : g_oe_lo
      assign drive = ~oe;
    end
  endgenerate

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && !fall) |=> (le || dout == $past(dout)));

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && fall) |=> (le || dout == $past(din)));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (le || dout == '0));
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int unsigned W = ubt_pkg::UBT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         le_ab,
  input  logic         le_ba,
  input  logic         ck_ab,
  input  logic         ck_ba,
  output logic         contention
);
  ubt_path #(.W(W), .POL(ubt_pkg::OE_ACT_HIGH)) u_ab (
    .clk   (clk),
    .rst   (rst),
    .din   (a_in),
    .le    (le_ab),
    .ck    (ck_ab),
    .oe    (en_ab),
    .dout  (b_out),
    .drive (b_drive)
  );

  ubt_path #(.W(W), .POL(ubt_pkg::OE_ACT_LOW)) u_ba (
    .clk   (clk),
    .rst   (rst),
    .din   (b_in),
    .le    (le_ba),
    .ck    (ck_ba),
    .oe    (en_ba_n),
    .dout  (a_out),
    .drive (a_drive)
  );

  assign contention = a_drive & b_drive;

  // R10
  contention_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (en_ab && !en_ba_n) == contention);
endmodule

// File: tb/tb_ubt_xcvr.sv
module tb_ubt_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive, contention;
  logic         en_ab = 1'b0, en_ba_n = 1'b1;
  logic         le_ab = 1'b0, le_ba = 1'b0;
  logic         ck_ab = 1'b0, ck_ba = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ubt_xcvr #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .en_ab(en_ab), .en_ba_n(en_ba_n),
    .le_ab(le_ab), .le_ba(le_ba),
    .ck_ab(ck_ab), .ck_ba(ck_ba),
    .contention(contention)
  );

  typedef struct packed {
    logic         le;
    logic         ck;
    logic         oe;
    logic [17:0]  din;
    logic [17:0]  exp;
  } vec_t;

  // A-to-B walk: le, ck, en_ab, a_in, expected b_out (checked after the edge)
  localparam vec_t VEC [13] = '{
    '{1'b0, 1'b0, 1'b1, 18'h11111, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 18'h12345, 18'h12345},
    '{1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA},
    '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h2AAAA},
    '{1'b0, 1'b1, 1'b1, 18'h0F0F0, 18'h2AAAA},
    '{1'b0, 1'b1, 1'b0, 18'h00111, 18'h2AAAA},
    '{1'b0, 1'b0, 1'b0, 18'h3C3C3, 18'h3C3C3},
    '{1'b0, 1'b0, 1'b1, 18'h01234, 18'h3C3C3},
    '{1'b0, 1'b1, 1'b1, 18'h22222, 18'h3C3C3},
    '{1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h3FFFF},
    '{1'b1, 1'b1, 1'b1, 18'h00001, 18'h00001},
    '{1'b0, 1'b1, 1'b1, 18'h00002, 18'h00001},
    '{1'b0, 1'b0, 1'b1, 18'h00003, 18'h00003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle;
    @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Table walk, A-to-B path (R1 R2 R3 R4 R5 R8 R9); B-to-A stays disabled
    for (int i = 0; i < 13; i++) begin
      if (i != 0) @(negedge clk);
      le_ab = VEC[i].le;
      ck_ab = VEC[i].ck;
      en_ab = VEC[i].oe;
      a_in  = VEC[i].din;
      settle();
      chk($sformatf("R1-path vec%0d b_out (R2 R3 R4 R8)", i), 32'(b_out), 32'(VEC[i].exp));
      chk($sformatf("R5 vec%0d b_drive", i), 32'(b_drive), 32'(VEC[i].oe));
      chk($sformatf("R10 vec%0d no contention", i), 32'(contention), 32'd0);
    end

    // B-to-A transparent with A-to-B still enabled (R7 R6 R10)
    @(negedge clk);
    en_ba_n = 1'b0; le_ba = 1'b1; b_in = 18'h1ABCD;
    #1;
    chk("R7 transparent a_out", 32'(a_out), 32'h1ABCD);
    chk("R6 a_drive on", 32'(a_drive), 32'd1);
    chk("R10 contention on", 32'(contention), 32'd1);
    settle();

    // Close latch with clock high, then falling edge captures (R7)
    @(negedge clk);
    le_ba = 1'b0; ck_ba = 1'b1; b_in = 18'h00000;
    settle();
    chk("R7 hold after latch close", 32'(a_out), 32'h1ABCD);
    @(negedge clk);
    ck_ba = 1'b0; b_in = 18'h05A5A;
    settle();
    chk("R7 falling edge capture", 32'(a_out), 32'h05A5A);
    chk("R11 b_out untouched", 32'(b_out), 32'h00003);

    // A-to-B capture leaves B-to-A stored word alone (R11)
    @(negedge clk);
    ck_ab = 1'b1; a_in = 18'h00777;
    settle();
    @(negedge clk);
    ck_ab = 1'b0;
    settle();
    chk("R3 second capture", 32'(b_out), 32'h00777);
    chk("R11 a_out untouched", 32'(a_out), 32'h05A5A);

    // Disable B-to-A drive (R6 R10)
    @(negedge clk);
    en_ba_n = 1'b1;
    #1;
    chk("R6 a_drive off", 32'(a_drive), 32'd0);
    chk("R10 contention off", 32'(contention), 32'd0);

    // Mid-run reset (R9)
    @(negedge clk);
    rst = 1'b1;
    settle();
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R9 b_out cleared", 32'(b_out), 32'd0);
    chk("R9 a_out cleared", 32'(a_out), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule